// File: doc/BRIEF.md
# Address Translation Sequencer with Fault Encoding

This block runs the top-level flow of a 32-bit address translation. It takes one request at a time: an effective address, the kind of access (load, store or instruction fetch), the two translation-enable bits of the machine state and the privilege level. It picks one of five outcomes in a fixed order. Real mode passes the address through. A block-translation hit supplies the physical address. A direct-store segment is either a forced memory access or a fault. A segment marked no-execute rejects fetches. Every other access goes to a hashed page-table walk, which has a primary pass and a secondary pass.

The block translator and the page-table searcher are separate units. The sequencer sends each of them a one-cycle request pulse and waits for its one-cycle done pulse. It selects the segment register from the top address nibble. From that register it derives the protection key, the no-execute flag and the segment identifier that the walker needs. It then finishes with a one-cycle done strobe. The strobe carries either a physical address or a fault record: the exception kind, the status word and the faulting address. On a fault, the status word depends on the cause and on whether the access was a store.

Top module: `tseq_top`

## Requirements
- R1: Access kind encoding: 0 load, 1 store, 2 fetch. A fetch with `itrans_en_i` low, or a load or store with `dtrans_en_i` low, completes with `pa_o` equal to the effective address and no fault. No block or walk request is issued.
- R2: With `blk_present_i` high and translation on, the block translator is asked first. A hit with rights granted returns `blk_pa_i`. A hit with rights denied is a protection fault. A miss moves on to the segment path. With `blk_present_i` low, no block request is issued.
- R3: The segment register is chosen by effective-address bits 31..28; register n sits at bits 32n+31..32n of `seg_regs_i`. The walk request carries that register's bits 23..0 as the segment identifier.
- R4: A segment whose bit 31 (direct-store) is set and whose bits 28..20 equal 0x07F is a forced memory access. Its physical address is segment bits 3..0 followed by effective-address bits 27..0. No protection check applies, and this holds for fetches too.
- R5: A fetch from any other direct-store segment, or from a segment with bit 28 (no-execute) set, faults with status 0x10000000 and issues no walk request.
- R6: The walk key is segment bit 29 in user mode (`user_mode_i` high) and segment bit 30 in supervisor mode.
- R7: Fault kind encoding: 0 none, 1 instruction, 2 data. A data fault for a missing translation reports 0x40000000, or 0x42000000 for a store. A data protection fault reports 0x08000000, or 0x0A000000 for a store. Every fault reports the effective address on `fault_addr_o`. A successful translation reports kind 0 and status 0.
- R8: An instruction fault for a missing translation reports 0x40000000, and an instruction protection fault reports 0x08000000.
- R9: A walk miss on the primary pass (`walk_pass_o` 0) issues a secondary pass (`walk_pass_o` 1). A miss on both passes is a not-found fault. A matched entry with rights denied is a protection fault. A matched entry with rights granted returns `walk_pa_i`.
- R10: `done_o` is high for exactly one cycle per request. `req_ready_o` is high only while idle, and it is high after reset.
- R11: A load or store to a direct-store segment that is not forced is a data protection fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request strobe, taken while idle |
| req_ready_o | output | 1 | Sequencer is idle |
| req_ea_i | input | 32 | Effective address |
| req_kind_i | input | 2 | Access kind |
| itrans_en_i | input | 1 | Instruction translation enable |
| dtrans_en_i | input | 1 | Data translation enable |
| user_mode_i | input | 1 | Problem (user) state |
| blk_present_i | input | 1 | At least one block entry is configured |
| seg_regs_i | input | 512 | Sixteen segment registers, flattened |
| blk_req_o | output | 1 | Block translator request pulse |
| blk_ea_o | output | 32 | Address for the block translator |
| blk_kind_o | output | 2 | Access kind for the block translator |
| blk_user_o | output | 1 | Privilege for the block translator |
| blk_done_i | input | 1 | Block translator done |
| blk_hit_i | input | 1 | Block entry matched |
| blk_ok_i | input | 1 | Block rights granted |
| blk_pa_i | input | 32 | Block physical address |
| walk_req_o | output | 1 | Page walk request pulse |
| walk_pass_o | output | 1 | 0 primary, 1 secondary hash |
| walk_vsid_o | output | 24 | Segment identifier |
| walk_ea_o | output | 32 | Address for the walker |
| walk_key_o | output | 1 | Protection key |
| walk_nx_o | output | 1 | Segment no-execute flag |
| walk_kind_o | output | 2 | Access kind for the walker |
| walk_done_i | input | 1 | Walk pass done |
| walk_found_i | input | 1 | Entry matched in this pass |
| walk_ok_i | input | 1 | Entry rights granted |
| walk_pa_i | input | 32 | Walk physical address |
| done_o | output | 1 | Result strobe |
| fault_o | output | 1 | Result is a fault |
| pa_o | output | 32 | Physical address |
| fault_kind_o | output | 2 | Exception kind |
| fault_status_o | output | 32 | Fault status word |
| fault_addr_o | output | 32 | Faulting effective address |

## Verification
The assertions assume that each sub-unit answers a request with exactly one done pulse. They also assume that the request inputs and segment registers stay stable while a request is in flight, and that the access kind is never 3. The bench models the block translator and walker as responders that answer each request pulse with a single done pulse one cycle later. It changes modes and segment contents only between requests, and it issues only the three legal kinds.

// File: rtl/tseq_pkg.sv
package tseq_pkg;
  localparam int SR_W      = 32;
  localparam int SR_DS_BIT = 31;
  localparam int SR_KS_BIT = 30;
  localparam int SR_KP_BIT = 29;
  localparam int SR_NX_BIT = 28;
  localparam logic [8:0] FORCED_BUID = 9'h07F;

  localparam logic [1:0] ACC_LOAD  = 2'd0;
  localparam logic [1:0] ACC_STORE = 2'd1;
  localparam logic [1:0] ACC_FETCH = 2'd2;

  localparam logic [1:0] FK_NONE = 2'd0;
  localparam logic [1:0] FK_INST = 2'd1;
  localparam logic [1:0] FK_DATA = 2'd2;

  typedef enum logic [1:0] {RS_NONE, RS_NOTFOUND, RS_PROT, RS_NOEXEC} rsn_t;

  function automatic logic pick_key(logic ks, logic kp, logic user);
    return user ? kp : ks;
  endfunction

  function automatic logic [31:0] fault_word(rsn_t r, logic fetch, logic store);
    logic [31:0] w;
    case (r)
      RS_NOTFOUND: w = 32'h4000_0000;
      RS_PROT:     w = 32'h0800_0000;
      RS_NOEXEC:   w = 32'h1000_0000;
      default:     w = 32'h0;
    endcase
    if (!fetch && store && r != RS_NONE) w = w | 32'h0200_0000;
    return w;
  endfunction
endpackage

// File: rtl/tseq_seg_decode.sv
module tseq_seg_decode
  import tseq_pkg::*;
#(
  parameter int EA_W   = 32,
  parameter int SEG_N  = 16,
  parameter int VSID_W = 24
) (
  input  logic [SEG_N*SR_W-1:0] seg_regs_i,
  input  logic [EA_W-1:0]       ea_i,
  input  logic                  user_i,
  output logic                  ds_o,
  output logic                  forced_o,
  output logic                  nx_o,
  output logic                  key_o,
  output logic [VSID_W-1:0]     vsid_o,
  output logic [EA_W-1:0]       forced_pa_o
);
  localparam int SEL_W = $clog2(SEG_N);

  logic [SEL_W-1:0] sel;
  logic [SR_W-1:0]  sr;

  assign sel = ea_i[EA_W-1 -: SEL_W];
  assign sr  = seg_regs_i[sel*SR_W +: SR_W];

  assign ds_o        = sr[SR_DS_BIT];
  assign forced_o    = sr[SR_DS_BIT] && (sr[28:20] == FORCED_BUID);
  assign nx_o        = sr[SR_NX_BIT];
  assign key_o       = pick_key(sr[SR_KS_BIT], sr[SR_KP_BIT], user_i);
  assign vsid_o      = sr[VSID_W-1:0];
  assign forced_pa_o = {sr[SEL_W-1:0], ea_i[EA_W-SEL_W-1:0]};
endmodule

// File: rtl/tseq_fault_enc.sv
module tseq_fault_enc
  import tseq_pkg::*;
(
  input  rsn_t        reason_i,
  input  logic [1:0]  kind_i,
  output logic [1:0]  fkind_o,
  output logic [31:0] status_o
);
  logic is_fetch;
  assign is_fetch = (kind_i == ACC_FETCH);
  assign fkind_o  = (reason_i == RS_NONE) ? FK_NONE : (is_fetch ? FK_INST : FK_DATA);
  assign status_o = fault_word(reason_i, is_fetch, kind_i == ACC_STORE);
endmodule

// File: rtl/tseq_top.sv
module tseq_top
  import tseq_pkg::*;
#(
  parameter int EA_W   = 32,
  parameter int SEG_N  = 16,
  parameter int VSID_W = 24
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid_i,
  output logic                  req_ready_o,
  input  logic [EA_W-1:0]       req_ea_i,
  input  logic [1:0]            req_kind_i,
  input  logic                  itrans_en_i,
  input  logic                  dtrans_en_i,
  input  logic                  user_mode_i,
  input  logic                  blk_present_i,
  input  logic [SEG_N*32-1:0]   seg_regs_i,
  output logic                  blk_req_o,
  output logic [EA_W-1:0]       blk_ea_o,
  output logic [1:0]            blk_kind_o,
  output logic                  blk_user_o,
  input  logic                  blk_done_i,
  input  logic                  blk_hit_i,
  input  logic                  blk_ok_i,
  input  logic [EA_W-1:0]       blk_pa_i,
  output logic                  walk_req_o,
  output logic                  walk_pass_o,
  output logic [VSID_W-1:0]     walk_vsid_o,
  output logic [EA_W-1:0]       walk_ea_o,
  output logic                  walk_key_o,
  output logic                  walk_nx_o,
  output logic [1:0]            walk_kind_o,
  input  logic                  walk_done_i,
  input  logic                  walk_found_i,
  input  logic                  walk_ok_i,
  input  logic [EA_W-1:0]       walk_pa_i,
  output logic                  done_o,
  output logic                  fault_o,
  output logic [EA_W-1:0]       pa_o,
  output logic [1:0]            fault_kind_o,
  output logic [31:0]           fault_status_o,
  output logic [EA_W-1:0]       fault_addr_o
);
  typedef enum logic [2:0] {ST_IDLE, ST_START, ST_BLK, ST_SEG, ST_WALK} st_t;

  st_t             st_q, st_n;
  logic [EA_W-1:0] ea_q;
  logic [1:0]      kind_q;
  logic            pass_q, pass_n;

  logic            fin, blk_fire, walk_fire;
  rsn_t            reason;
  logic [EA_W-1:0] pa_n;

  logic            seg_ds, seg_forced, seg_nx, seg_key;
  logic [VSID_W-1:0] seg_vsid;
  logic [EA_W-1:0] forced_pa;
  logic [1:0]      enc_fkind;
  logic [31:0]     enc_status;
  logic            is_fetch, real_mode;

  assign is_fetch  = (kind_q == ACC_FETCH);
  assign real_mode = is_fetch ? !itrans_en_i : !dtrans_en_i;

  tseq_seg_decode #(.EA_W(EA_W), .SEG_N(SEG_N), .VSID_W(VSID_W)) u_seg (
    .seg_regs_i (seg_regs_i),
    .ea_i       (ea_q),
    .user_i     (user_mode_i),
    .ds_o       (seg_ds),
    .forced_o   (seg_forced),
    .nx_o       (seg_nx),
    .key_o      (seg_key),
    .vsid_o     (seg_vsid),
    .forced_pa_o(forced_pa)
  );

  tseq_fault_enc u_enc (
    .reason_i (reason),
    .kind_i   (kind_q),
    .fkind_o  (enc_fkind),
    .status_o (enc_status)
  );

  always_comb begin
    st_n      = st_q;
    pass_n    = pass_q;
    fin       = 1'b0;
    reason    = RS_NONE;
    pa_n      = '0;
    blk_fire  = 1'b0;
    walk_fire = 1'b0;
    case (st_q)
      ST_IDLE: if (req_valid_i) st_n = ST_START;
      ST_START: begin
        if (real_mode) begin
          fin  = 1'b1;
          pa_n = ea_q;
        end else if (blk_present_i) begin
          blk_fire = 1'b1;
          st_n     = ST_BLK;
        end else begin
          st_n = ST_SEG;
        end
      end
      ST_BLK: if (blk_done_i) begin
        if (blk_hit_i) begin
          fin = 1'b1;
          if (blk_ok_i) pa_n = blk_pa_i;
          else          reason = RS_PROT;
        end else begin
          st_n = ST_SEG;
        end
      end
      ST_SEG: begin
        if (seg_ds) begin
          fin = 1'b1;
          if (seg_forced)    pa_n = forced_pa;
          else if (is_fetch) reason = RS_NOEXEC;
          else               reason = RS_PROT;
        end else if (is_fetch && seg_nx) begin
          fin    = 1'b1;
          reason = RS_NOEXEC;
        end else begin
          walk_fire = 1'b1;
          pass_n    = 1'b0;
          st_n      = ST_WALK;
        end
      end
      ST_WALK: if (walk_done_i) begin
        if (walk_found_i) begin
          fin = 1'b1;
          if (walk_ok_i) pa_n = walk_pa_i;
          else           reason = RS_PROT;
        end else if (!pass_q) begin
          walk_fire = 1'b1;
          pass_n    = 1'b1;
        end else begin
          fin    = 1'b1;
          reason = RS_NOTFOUND;
        end
      end
      default: st_n = ST_IDLE;
    endcase
    if (fin) st_n = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q           <= ST_IDLE;
      ea_q           <= '0;
      kind_q         <= ACC_LOAD;
      pass_q         <= 1'b0;
      blk_req_o      <= 1'b0;
      walk_req_o     <= 1'b0;
      done_o         <= 1'b0;
      fault_o        <= 1'b0;
      pa_o           <= '0;
      fault_kind_o   <= FK_NONE;
      fault_status_o <= '0;
      fault_addr_o   <= '0;
    end else begin
      st_q       <= st_n;
      pass_q     <= pass_n;
      blk_req_o  <= blk_fire;
      walk_req_o <= walk_fire;
      done_o     <= fin;
      if (st_q == ST_IDLE && req_valid_i) begin
        ea_q   <= req_ea_i;
        kind_q <= req_kind_i;
      end
      if (fin) begin
        fault_o        <= (reason != RS_NONE);
        pa_o           <= pa_n;
        fault_kind_o   <= enc_fkind;
        fault_status_o <= enc_status;
        fault_addr_o   <= (reason != RS_NONE) ? ea_q : '0;
      end
    end
  end

  assign req_ready_o = (st_q == ST_IDLE);
  assign blk_ea_o    = ea_q;
  assign blk_kind_o  = kind_q;
  assign blk_user_o  = user_mode_i;
  assign walk_pass_o = pass_q;
  assign walk_vsid_o = seg_vsid;
  assign walk_ea_o   = ea_q;
  assign walk_key_o  = seg_key;
  assign walk_nx_o   = seg_nx;
  assign walk_kind_o = kind_q;

  // R2: the two sub-units are never asked in the same cycle
  p_one_sub_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(blk_req_o && walk_req_o));

  // R10: a result strobe lasts one cycle and leaves the sequencer idle
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> req_ready_o);

  // R5: no walk for a fetch from a no-execute segment
  p_no_walk_nx_r5: assert property (@(posedge clk) disable iff (!rst_n)
    walk_req_o |-> !(walk_kind_o == ACC_FETCH && walk_nx_o));

  // R9: the secondary pass only follows a primary miss
  p_pass1_after_miss_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_req_o && walk_pass_o) |-> $past(walk_done_i && !walk_found_i));

  // R7: a fault record always names an exception kind
  p_fault_kind_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && fault_o) |-> (fault_kind_o != FK_NONE));
endmodule

// File: tb/tseq_top_tb_top.sv
module tseq_top_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        req_valid_i = 1'b0, req_ready_o;
  logic [31:0] req_ea_i = '0;
  logic [1:0]  req_kind_i = '0;
  logic        itrans_en_i = 1'b1, dtrans_en_i = 1'b1, user_mode_i = 1'b0, blk_present_i = 1'b0;
  logic [31:0] seg [16];
  logic [511:0] seg_flat;
  logic        blk_req_o, blk_user_o, blk_done_i = 1'b0, blk_hit_i = 1'b0, blk_ok_i = 1'b0;
  logic [31:0] blk_ea_o, blk_pa_i = '0;
  logic [1:0]  blk_kind_o, walk_kind_o;
  logic        walk_req_o, walk_pass_o, walk_key_o, walk_nx_o;
  logic [23:0] walk_vsid_o;
  logic [31:0] walk_ea_o, walk_pa_i = '0;
  logic        walk_done_i = 1'b0, walk_found_i = 1'b0, walk_ok_i = 1'b0;
  logic        done_o, fault_o;
  logic [31:0] pa_o, fault_status_o, fault_addr_o;
  logic [1:0]  fault_kind_o;

  always_comb for (int i = 0; i < 16; i++) seg_flat[i*32 +: 32] = seg[i];

  tseq_top dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
    .req_ea_i(req_ea_i), .req_kind_i(req_kind_i), .itrans_en_i(itrans_en_i),
    .dtrans_en_i(dtrans_en_i), .user_mode_i(user_mode_i), .blk_present_i(blk_present_i),
    .seg_regs_i(seg_flat), .blk_req_o(blk_req_o), .blk_ea_o(blk_ea_o),
    .blk_kind_o(blk_kind_o), .blk_user_o(blk_user_o), .blk_done_i(blk_done_i),
    .blk_hit_i(blk_hit_i), .blk_ok_i(blk_ok_i), .blk_pa_i(blk_pa_i),
    .walk_req_o(walk_req_o), .walk_pass_o(walk_pass_o), .walk_vsid_o(walk_vsid_o),
    .walk_ea_o(walk_ea_o), .walk_key_o(walk_key_o), .walk_nx_o(walk_nx_o),
    .walk_kind_o(walk_kind_o), .walk_done_i(walk_done_i), .walk_found_i(walk_found_i),
    .walk_ok_i(walk_ok_i), .walk_pa_i(walk_pa_i), .done_o(done_o), .fault_o(fault_o),
    .pa_o(pa_o), .fault_kind_o(fault_kind_o), .fault_status_o(fault_status_o),
    .fault_addr_o(fault_addr_o)
  );

  int n_chk = 0, n_fail = 0;
  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // sub-unit models and their configuration
  logic        c_bhit = 0, c_bok = 0, c_f0 = 0, c_f1 = 0, c_wok = 0;
  logic [31:0] c_bpa = '0, c_wpa = '0;
  int          n_blk = 0, n_walk = 0;
  logic        last_key = 0;
  logic [23:0] last_vsid = '0;

  always @(negedge clk) begin
    blk_done_i  = blk_req_o;
    blk_hit_i   = c_bhit;
    blk_ok_i    = c_bok;
    blk_pa_i    = c_bpa;
    walk_done_i = walk_req_o;
    walk_found_i = walk_pass_o ? c_f1 : c_f0;
    walk_ok_i   = c_wok;
    walk_pa_i   = c_wpa;
    if (blk_req_o) n_blk++;
    if (walk_req_o) begin
      n_walk++;
      last_key  = walk_key_o;
      last_vsid = walk_vsid_o;
    end
  end

  // scoreboard
  typedef struct {
    logic        flt;
    logic [31:0] pa;
    logic [1:0]  fk;
    logic [31:0] st;
    logic [31:0] ad;
    string       tag;
  } exp_t;
  exp_t q[$];
  int   n_done = 0;

  always @(negedge clk) begin
    if (done_o) begin
      n_done++;
      if (q.size() == 0) begin
        chk(1'b0, "R10 unexpected done", 32'd1, 32'd0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(fault_o == e.flt, {e.tag, " fault flag"}, {31'd0, fault_o}, {31'd0, e.flt});
        if (!e.flt) chk(pa_o == e.pa, {e.tag, " pa"}, pa_o, e.pa);
        chk(fault_kind_o == e.fk, {e.tag, " kind"}, {30'd0, fault_kind_o}, {30'd0, e.fk});
        chk(fault_status_o == e.st, {e.tag, " status"}, fault_status_o, e.st);
        if (e.flt) chk(fault_addr_o == e.ad, {e.tag, " addr"}, fault_addr_o, e.ad);
      end
    end
  end

  task automatic run(input logic [31:0] ea, input logic [1:0] kind, input logic flt,
                     input logic [31:0] pa, input logic [1:0] fk, input logic [31:0] st,
                     input string tag);
    exp_t e;
    e.flt = flt; e.pa = pa; e.fk = fk; e.st = st; e.ad = ea; e.tag = tag;
    @(negedge clk);
    while (!req_ready_o) @(negedge clk);
    q.push_back(e);
    req_valid_i = 1'b1; req_ea_i = ea; req_kind_i = kind;
    @(negedge clk);
    req_valid_i = 1'b0;
    for (int k = 0; k < 50 && q.size() != 0; k++) @(negedge clk);
    if (q.size() != 0) begin
      chk(1'b0, {tag, " R10 no done"}, 32'd0, 32'd1);
      q.delete();
    end
    @(negedge clk);
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 100000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int b0, w0;
    for (int i = 0; i < 16; i++) seg[i] = 32'h0000_0100 + i;
    seg[3] = 32'h8000_0000 | (32'h07F << 20) | 32'hA;  // forced
    seg[4] = 32'h8000_0000 | 32'h5;                    // plain direct-store
    seg[6] = 32'h1000_0000 | 32'h106;                  // no-execute
    seg[7] = 32'h4000_0000 | 32'h107;                  // supervisor key
    seg[8] = 32'h2000_0000 | 32'h108;                  // user key
    repeat (3) @(negedge clk);
    chk(req_ready_o == 1'b1, "R10 ready after reset", {31'd0, req_ready_o}, 32'd1);
    chk(done_o == 1'b0, "R10 no done in reset", {31'd0, done_o}, 32'd0);
    rst_n = 1'b1;

    // R1 real mode
    itrans_en_i = 0; blk_present_i = 1; b0 = n_blk; w0 = n_walk;
    run(32'h1234_5678, 2'd2, 0, 32'h1234_5678, 2'd0, 32'h0, "R1 fetch real");
    itrans_en_i = 1; dtrans_en_i = 0;
    run(32'h9ABC_DEF0, 2'd1, 0, 32'h9ABC_DEF0, 2'd0, 32'h0, "R1 store real");
    dtrans_en_i = 1;
    chk(n_blk == b0 && n_walk == w0, "R1 no sub requests", n_blk + n_walk, b0 + w0);

    // R2 block translation
    c_bhit = 1; c_bok = 1; c_bpa = 32'hABCD_0123;
    run(32'h2000_0123, 2'd0, 0, 32'hABCD_0123, 2'd0, 32'h0, "R2 block hit");
    c_bok = 0;
    run(32'h2000_0456, 2'd1, 1, 0, 2'd2, 32'h0A00_0000, "R2 block denied store");
    c_bhit = 0; c_f0 = 1; c_wok = 1; c_wpa = 32'h0055_5000; w0 = n_walk;
    run(32'h2000_0789, 2'd0, 0, 32'h0055_5000, 2'd0, 32'h0, "R2 block miss to walk");
    chk(n_walk == w0 + 1, "R2 walk after block miss", n_walk, w0 + 1);
    blk_present_i = 0; b0 = n_blk;
    run(32'h1000_0000, 2'd0, 0, 32'h0055_5000, 2'd0, 32'h0, "R2 no blocks");
    chk(n_blk == b0, "R2 block skipped", n_blk, b0);

    // R3 segment select
    run(32'h5111_2222, 2'd0, 0, 32'h0055_5000, 2'd0, 32'h0, "R3 seg5 walk");
    chk(last_vsid == 24'h105, "R3 vsid seg5", {8'd0, last_vsid}, 32'h105);
    run(32'hF000_0000, 2'd0, 0, 32'h0055_5000, 2'd0, 32'h0, "R3 seg15 walk");
    chk(last_vsid == 24'h10F, "R3 vsid seg15", {8'd0, last_vsid}, 32'h10F);

    // R4 forced direct-store
    w0 = n_walk;
    run(32'h3123_4567, 2'd2, 0, 32'hA123_4567, 2'd0, 32'h0, "R4 forced fetch");
    run(32'h3FFF_FFFF, 2'd1, 0, 32'hAFFF_FFFF, 2'd0, 32'h0, "R4 forced store");
    chk(n_walk == w0, "R4 no walk", n_walk, w0);

    // R5 fetch from direct-store / no-execute
    run(32'h4000_1000, 2'd2, 1, 0, 2'd1, 32'h1000_0000, "R5 fetch direct-store");
    run(32'h6000_2000, 2'd2, 1, 0, 2'd1, 32'h1000_0000, "R5 fetch no-exec");
    chk(n_walk == w0, "R5 no walk", n_walk, w0);
    run(32'h6000_3000, 2'd0, 0, 32'h0055_5000, 2'd0, 32'h0, "R5 load no-exec segment");

    // R11 data to plain direct-store
    run(32'h4000_0040, 2'd0, 1, 0, 2'd2, 32'h0800_0000, "R11 load direct-store");
    run(32'h4000_0080, 2'd1, 1, 0, 2'd2, 32'h0A00_0000, "R11 store direct-store");

    // R6 keys
    user_mode_i = 0;
    run(32'h7000_1000, 2'd0, 0, 32'h0055_5000, 2'd0, 32'h0, "R6 sup ks");
    chk(last_key == 1, "R6 key sup ks", {31'd0, last_key}, 32'd1);
    user_mode_i = 1;
    run(32'h7000_1000, 2'd0, 0, 32'h0055_5000, 2'd0, 32'h0, "R6 user ks");
    chk(last_key == 0, "R6 key user ks", {31'd0, last_key}, 32'd0);
    run(32'h8000_1000, 2'd0, 0, 32'h0055_5000, 2'd0, 32'h0, "R6 user kp");
    chk(last_key == 1, "R6 key user kp", {31'd0, last_key}, 32'd1);
    user_mode_i = 0;
    run(32'h8000_1000, 2'd0, 0, 32'h0055_5000, 2'd0, 32'h0, "R6 sup kp");
    chk(last_key == 0, "R6 key sup kp", {31'd0, last_key}, 32'd0);

    // R7 / R8 / R9 walk outcomes
    c_f0 = 0; c_f1 = 0; w0 = n_walk;
    run(32'h1234_0000, 2'd0, 1, 0, 2'd2, 32'h4000_0000, "R7 load miss");
    chk(n_walk == w0 + 2, "R9 two passes on miss", n_walk, w0 + 2);
    run(32'h1234_0004, 2'd1, 1, 0, 2'd2, 32'h4200_0000, "R7 store miss");
    run(32'h1234_0008, 2'd2, 1, 0, 2'd1, 32'h4000_0000, "R8 fetch miss");
    c_f0 = 1; c_wok = 0;
    run(32'h1234_000C, 2'd0, 1, 0, 2'd2, 32'h0800_0000, "R7 load prot");
    run(32'h1234_0010, 2'd2, 1, 0, 2'd1, 32'h0800_0000, "R8 fetch prot");
    c_f0 = 0; c_f1 = 1; c_wok = 1; c_wpa = 32'h00AA_B000; w0 = n_walk;
    run(32'h1234_0014, 2'd1, 0, 32'h00AA_B000, 2'd0, 32'h0, "R9 secondary hit");
    chk(n_walk == w0 + 2, "R9 secondary pass issued", n_walk, w0 + 2);
    c_wok = 0;
    run(32'h1234_0018, 2'd1, 1, 0, 2'd2, 32'h0A00_0000, "R9 secondary prot store");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule